// File: doc/BRIEF.md
# Parity-Protected Simple Dual-Port RAM

This block wraps a storage array with one write port and one read port that share a single clock. Every word is stored with an extra even-parity bit that is computed on the write side. A checker on the read side tests that bit. Both ports register their address through a register that has a stall input. While stall is high, the register keeps the address it loaded earlier. All paths into these registers are synchronous to the one clock.

The block does not model the array contents at power-up: they are unknown. A valid bit for each word is cleared by reset and set by the first write to that word. A read of a word that has never been written is flagged on the read port.

A parameter selects what a read returns when it hits the word being written in the same cycle: the new word, the old word, or an undefined value. The undefined value is modelled as the old word XORed with a pseudo-random mask. In undefined mode the parity flag is suppressed for such collisions, and every other read is still checked.

Top module: `parity_dpram`

## Requirements
- R1: A read request (`rd_en` high with the address loaded) is sampled at clock edge k. At edge k+1, `rd_valid` rises and `rd_data` shows the stored word of the registered read address. `rd_valid` is low after any edge that did not follow a read request.
- R2: With `RDW_MODE` = 2'b00 (new data), a read whose registered address equals the registered write address of an active write in the same cycle returns the data being written.
- R3: With `RDW_MODE` = 2'b01 (old data), such a collision read returns the word that was stored before that write.
- R4: With `RDW_MODE` = 2'b10 (undefined), a collision read may return any value, and `rd_perr` stays low for it.
- R5: Each stored word carries an even-parity bit over the data. `rd_perr` is high only when the word read back, including its parity bit, has odd weight, and the read is neither an undefined-mode collision nor an uninitialised read. For words written through the port, `rd_perr` therefore stays low.
- R6: While `wr_stall` is high at an edge, the write address register keeps its previous value, so a write goes to the held address and not to `wr_addr`.
- R7: While `rd_stall` is high at an edge, the read address register keeps its previous value.
- R8: Reset clears all per-word valid bits. A read of a word not written since reset raises `rd_uninit` together with `rd_valid`. A new-data collision read counts as written.
- R9: `rd_perr` and `rd_uninit` are high only together with `rd_valid`. During reset and in the cycles after it, `rd_valid`, `rd_perr` and `rd_uninit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchroniser |
| wr_en | input | 1 | Write request |
| wr_stall | input | 1 | Hold the write address register |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_stall | input | 1 | Hold the read address register |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| rd_perr | output | 1 | Parity error on the current read |
| rd_uninit | output | 1 | Current read hit a word never written since reset |

## Verification
The bench builds three copies with DATA_W = 8 and ADDR_W = 3, one for each of the collision modes 2'b00, 2'b01 and 2'b10, and drives all three with the same stimulus. An eight-word array lets the bench fill every word, read all of them back, and force many same-address collisions in a short run. With all three modes side by side, each collision shows new data, old data and the suppressed parity flag at the same time. The small depth also makes it easy to aim stalled writes and reads at words whose valid state is known.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
   localparam logic [1:0] RDW_NEW      = 2'b00;
   localparam logic [1:0] RDW_OLD      = 2'b01;
   localparam logic [1:0] RDW_DONTCARE = 2'b10;

   function automatic logic even_par(input logic [63:0] v);
      return ^v;
   endfunction
endpackage

// File: rtl/pdr_reset_sync.sv
module pdr_reset_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_s_n
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_s_n = chain_q[STAGES-1];

   if (STAGES < 2) begin : g_bad
      $error("pdr_reset_sync: STAGES must be at least 2");
   end
endmodule

// File: rtl/pdr_addr_reg.sv
module pdr_addr_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stall,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (!stall) q <= d;
   end

   // R6 / R7: a stalled edge leaves the loaded address untouched
   a_r6_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> q == $past(q));
endmodule

// File: rtl/pdr_mask_gen.sv
module pdr_mask_gen #(
   parameter int W      = 9,
   parameter int LFSR_W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] mask
);
   localparam logic [LFSR_W-1:0] SEED = {{(LFSR_W-1){1'b0}}, 1'b1};
   localparam logic [LFSR_W-1:0] TAPS = 16'hB400;

   logic [LFSR_W-1:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          state_q <= SEED;
      else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
      else                 state_q <= state_q >> 1;
   end

   always_comb begin
      mask = '0;
      for (int j = 0; j < LFSR_W; j++) mask[j % W] = mask[j % W] ^ state_q[j];
   end

   if (LFSR_W != 16) begin : g_bad
      $error("pdr_mask_gen: tap constant is defined for a 16-bit register");
   end
endmodule

// File: rtl/parity_dpram.sv
module parity_dpram #(
   parameter int         DATA_W   = 8,
   parameter int         ADDR_W   = 4,
   parameter logic [1:0] RDW_MODE = 2'b00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_stall,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rd_stall,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_perr,
   output logic              rd_uninit
);
   import pdr_pkg::*;

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int WORD_W = DATA_W + 1;

   if (DATA_W < 1 || DATA_W > 63) begin : g_bad_w
      $error("parity_dpram: DATA_W out of range");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_a
      $error("parity_dpram: ADDR_W out of range");
   end
   if (RDW_MODE == 2'b11) begin : g_bad_m
      $error("parity_dpram: RDW_MODE 2'b11 is not defined");
   end

   logic rst_s_n;
   pdr_reset_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

   // input stage: address registers with stall, plus request/data registers
   logic [ADDR_W-1:0] wa_q, ra_q;
   logic              wen_q, ren_q;
   logic [DATA_W-1:0] wd_q;

   pdr_addr_reg #(.W(ADDR_W)) u_wa (.clk(clk), .rst_n(rst_s_n), .stall(wr_stall), .d(wr_addr), .q(wa_q));
   pdr_addr_reg #(.W(ADDR_W)) u_ra (.clk(clk), .rst_n(rst_s_n), .stall(rd_stall), .d(rd_addr), .q(ra_q));

   always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) begin
         wen_q <= 1'b0;
         ren_q <= 1'b0;
         wd_q  <= '0;
      end else begin
         wen_q <= wr_en;
         ren_q <= rd_en;
         wd_q  <= wr_data;
      end
   end

   // storage: contents are not reset, only the valid bits are
   logic [WORD_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  valid_q;
   logic [WORD_W-1:0] new_word, old_word;

   assign new_word = {even_par(64'(wd_q)), wd_q};
   assign old_word = mem[ra_q];

   always_ff @(posedge clk) begin
      if (wen_q) mem[wa_q] <= new_word;
   end

   always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)   valid_q <= '0;
      else if (wen_q) valid_q[wa_q] <= 1'b1;
   end

   logic coll;
   assign coll = wen_q & ren_q & (wa_q == ra_q);

   // collision behaviour chosen by parameter
   logic [WORD_W-1:0] word_nx;
   logic              uninit_nx;
   logic              dcc_nx;

   if (RDW_MODE == RDW_NEW) begin : g_new
      assign word_nx   = coll ? new_word : old_word;
      assign uninit_nx = ~valid_q[ra_q] & ~coll;
      assign dcc_nx    = 1'b0;
   end else if (RDW_MODE == RDW_OLD) begin : g_old
      assign word_nx   = old_word;
      assign uninit_nx = ~valid_q[ra_q];
      assign dcc_nx    = 1'b0;
   end else begin : g_dc
      logic [WORD_W-1:0] mask;
      pdr_mask_gen #(.W(WORD_W), .LFSR_W(16)) u_mask (.clk(clk), .rst_n(rst_s_n), .mask(mask));
      assign word_nx   = coll ? (old_word ^ mask) : old_word;
      assign uninit_nx = ~valid_q[ra_q];
      assign dcc_nx    = coll;
   end

   // output stage
   logic [WORD_W-1:0] rword_q;
   logic              rv_q, un_q, dcc_q;

   always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) begin
         rv_q    <= 1'b0;
         un_q    <= 1'b0;
         dcc_q   <= 1'b0;
         rword_q <= '0;
      end else begin
         rv_q  <= ren_q;
         un_q  <= ren_q & uninit_nx;
         dcc_q <= ren_q & dcc_nx;
         if (ren_q) rword_q <= word_nx;
      end
   end

   assign rd_valid  = rv_q;
   assign rd_data   = rword_q[DATA_W-1:0];
   assign rd_uninit = un_q;
   assign rd_perr   = rv_q & ~un_q & ~dcc_q & even_par(64'(rword_q));

   // R1: read data valid follows the registered request by one edge
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_s_n)
      ren_q |=> rd_valid);
   a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_s_n)
      !ren_q |=> !rd_valid);
   // R9: flags only with valid data
   a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_s_n)
      (rd_perr | rd_uninit) |-> rd_valid);
   // R5: a read of a written word, outside undefined-mode collisions, has good parity
   a_r5_written_word_clean: assert property (@(posedge clk) disable iff (!rst_s_n)
      (ren_q & valid_q[ra_q] & ~dcc_nx) |=> !rd_perr);

   if (RDW_MODE == RDW_NEW) begin : g_a_new
      // R2: new data returned on collision
      a_r2_new_on_coll: assert property (@(posedge clk) disable iff (!rst_s_n)
         coll |=> rd_data == $past(wd_q));
   end else if (RDW_MODE == RDW_OLD) begin : g_a_old
      // R3: previous contents returned on collision
      a_r3_old_on_coll: assert property (@(posedge clk) disable iff (!rst_s_n)
         (coll & valid_q[ra_q]) |=> rd_data == $past(old_word[DATA_W-1:0]));
   end else begin : g_a_dc
      // R4: collisions never raise the parity flag
      a_r4_dc_no_perr: assert property (@(posedge clk) disable iff (!rst_s_n)
         coll |=> !rd_perr);
   end
endmodule

// File: tb/sim_parity_dpram.sv
`timescale 1ns/1ps
module sim_parity_dpram;
   localparam int DW = 8;
   localparam int AW = 3;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          wr_en = 0, wr_stall = 0, rd_en = 0, rd_stall = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;

   logic          o_rv [3];
   logic [DW-1:0] o_dat [3];
   logic          o_pe [3];
   logic          o_un [3];

   parity_dpram #(.DATA_W(DW), .ADDR_W(AW), .RDW_MODE(2'b00)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stall(wr_stall), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_stall(rd_stall), .rd_addr(rd_addr),
      .rd_valid(o_rv[0]), .rd_data(o_dat[0]), .rd_perr(o_pe[0]), .rd_uninit(o_un[0]));
   parity_dpram #(.DATA_W(DW), .ADDR_W(AW), .RDW_MODE(2'b01)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stall(wr_stall), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_stall(rd_stall), .rd_addr(rd_addr),
      .rd_valid(o_rv[1]), .rd_data(o_dat[1]), .rd_perr(o_pe[1]), .rd_uninit(o_un[1]));
   parity_dpram #(.DATA_W(DW), .ADDR_W(AW), .RDW_MODE(2'b10)) u2 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stall(wr_stall), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_stall(rd_stall), .rd_addr(rd_addr),
      .rd_valid(o_rv[2]), .rd_data(o_dat[2]), .rd_perr(o_pe[2]), .rd_uninit(o_un[2]));

   int checks = 0;
   int errors = 0;
   bit chk_on = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   // behavioural reference model, shared write history, per-mode read result
   bit [DW-1:0] m_mem [DEPTH];
   bit          m_vld [DEPTH];
   int          m_wa = 0, m_ra = 0;
   bit          m_we = 0, m_re = 0;
   bit [DW-1:0] m_wd = 0;
   bit          e_rv = 0, e_col = 0;
   bit [DW-1:0] e_dat [3];
   bit          e_un [3];
   bit          e_dcc [3];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
         m_wa = 0; m_ra = 0; m_we = 0; m_re = 0; m_wd = 0;
         e_rv = 0; e_col = 0;
      end else begin
         bit c;
         c = m_we && m_re && (m_wa == m_ra);
         e_rv = m_re;
         e_col = c;
         for (int m = 0; m < 3; m++) begin
            e_un[m]  = !m_vld[m_ra] && !(m == 0 && c);
            e_dat[m] = (m == 0 && c) ? m_wd : m_mem[m_ra];
            e_dcc[m] = (m == 2) && c;
         end
         if (m_we) begin
            m_mem[m_wa] = m_wd;
            m_vld[m_wa] = 1;
         end
         if (!wr_stall) m_wa = int'(wr_addr);
         if (!rd_stall) m_ra = int'(rd_addr);
         m_we = wr_en; m_re = rd_en; m_wd = wr_data;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (chk_on && !done) begin
         for (int m = 0; m < 3; m++) begin
            chk(o_rv[m] == e_rv, "R1", o_rv[m], e_rv);
            if (e_rv) begin
               chk(o_un[m] == e_un[m], "R8", o_un[m], e_un[m]);
               chk(o_pe[m] == 1'b0, e_dcc[m] ? "R4" : "R5", o_pe[m], 0);
               if (!e_un[m] && !e_dcc[m])
                  chk(o_dat[m] == e_dat[m], (e_col && m == 0) ? "R2" : (e_col && m == 1) ? "R3" : "R1",
                      o_dat[m], e_dat[m]);
            end else begin
               chk(!o_un[m] && !o_pe[m], "R9", {o_un[m], o_pe[m]}, 0);
            end
         end
      end
   end

   task automatic drive(input bit we, input bit ws, input int wa, input int wd,
                        input bit re, input bit rs, input int ra);
      @(negedge clk);
      wr_en = we; wr_stall = ws; wr_addr = AW'(wa); wr_data = DW'(wd);
      rd_en = re; rd_stall = rs; rd_addr = AW'(ra);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      chk_on = 0;
      rst_n = 0;
      wr_en = 0; rd_en = 0; wr_stall = 0; rd_stall = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
      #1;
      for (int m = 0; m < 3; m++)  // R9: asynchronous clear of the read outputs
         chk(!o_rv[m] && !o_un[m] && !o_pe[m], "R9", {o_rv[m], o_un[m], o_pe[m]}, 0);
      idle(2);
      rst_n = 1;
      idle(4);
      chk_on = 1;
   endtask

   // directed read with known expectation on every mode (no collision)
   task automatic rd_expect(input int a, input int exp, input bit exp_un, input string tag);
      drive(0, 0, 0, 0, 1, 0, a);
      idle(1);
      @(negedge clk);
      for (int m = 0; m < 3; m++) begin
         chk(o_un[m] == exp_un, tag, o_un[m], exp_un);
         if (!exp_un) chk(o_dat[m] == DW'(exp), tag, o_dat[m], exp);
      end
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      idle(4);
      chk_on = 1;

      // R8: never-written word
      rd_expect(5, 0, 1, "R8");

      // R1/R5: fill every word, read all back
      for (int i = 0; i < DEPTH; i++) drive(1, 0, i, i * 37 + 5, 0, 0, 0);
      idle(1);
      for (int i = 0; i < DEPTH; i++) drive(0, 0, 0, 0, 1, 0, i);
      idle(2);
      rd_expect(6, 6 * 37 + 5, 0, "R1");

      // simultaneous write and read of different words
      for (int i = 0; i < DEPTH; i++) drive(1, 0, i, 8'hC0 ^ i, 1, 0, (i + 3) % DEPTH);
      idle(2);

      // R2/R3/R4: same-address collisions
      for (int i = 0; i < 12; i++) begin
         drive(1, 0, i % DEPTH, i * 29 + 1, 1, 0, i % DEPTH);
         drive(0, 0, 0, 0, 1, 0, (i + 1) % DEPTH);
      end
      for (int i = 0; i < 6; i++) drive(1, 0, 4, i * 51 + 7, 1, 0, 4);
      idle(2);

      // R8: reset clears valid bits
      do_reset();
      rd_expect(0, 0, 1, "R8");
      rd_expect(4, 0, 1, "R8");
      // collision on an unwritten word: new mode counts it written, others flag it
      drive(1, 0, 1, 8'h5A, 1, 0, 1);
      idle(3);

      // R6: stalled write address
      drive(1, 0, 2, 8'hA5, 0, 0, 0);
      drive(1, 1, 6, 8'h3C, 0, 0, 0);
      idle(2);
      rd_expect(6, 0, 1, "R6");
      rd_expect(2, 8'h3C, 0, "R6");

      // R7: stalled read address
      drive(0, 0, 0, 0, 1, 0, 2);
      drive(0, 0, 0, 0, 1, 1, 6);
      drive(0, 0, 0, 0, 0, 0, 0);
      for (int m = 0; m < 3; m++) chk(o_dat[m] == 8'h3C && !o_un[m], "R7", o_dat[m], 8'h3C);
      @(negedge clk);
      for (int m = 0; m < 3; m++) chk(o_dat[m] == 8'h3C && !o_un[m], "R7", o_dat[m], 8'h3C);
      idle(3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule